// File: doc/BRIEF.md
# Filtered Circular Bus Trace Buffer

This block watches a simplified bus-transfer observation interface. It records each qualifying transfer as one 128-bit entry in a ring of on-chip storage. Every entry carries a free-running cycle timestamp, the transfer address, the data word, and control fields: the initiating master id, the target slave id, the direction and a 2-bit transfer kind. When the ring is full, new entries overwrite the oldest ones. Three filters decide which transfers are kept. The first is a per-master bitmask and the second is a per-slave bitmask. The third is a pair of enables, one for read transfers and one for write transfers.

A debug master reads the ring through an independent word-wide port while capture keeps running. Each entry is read as four 32-bit words, selected by the two low bits of the read address. Tracing can be switched off, or frozen by an external request. The write pointer and a sticky wrap flag are visible, so software can find the oldest valid entry. A statistics option drives single-cycle event pulses for transfers that pass the filters. Turning statistics on also forces the filters on.

Top module: `bus_trace_buffer`

## Requirements
- R1: After a synchronous reset, `wr_ptr` is 0, `wrapped` is 0, `rd_valid` is 0 and all three event outputs are 0.
- R2: A stored entry is read back as four words. Word 0 packs {timestamp[15:0], master[3:0], slave[3:0], write, kind[1:0], 5'b0} from bit 31 down to bit 0. Word 1 is the address and word 2 is the data. Word 3 is the full 32-bit timestamp, which counts clock edges since reset was released.
- R3: Each stored transfer advances `wr_ptr` by one edge later. The pointer goes from DEPTH-1 back to 0. `wrapped` becomes 1 on that step and stays 1 until reset.
- R4: Once the ring has wrapped, a new entry replaces the oldest entry at the pointer slot, and the other slots keep their contents.
- R5: With filtering active, a transfer is dropped unless bit `obs_mst` of `mst_mask` is 1.
- R6: With filtering active, a transfer is dropped unless bit `obs_slv` of `slv_mask` is 1.
- R7: With filtering active, a write (`obs_write`=1) is dropped unless `keep_wr` is 1, and a read is dropped unless `keep_rd` is 1.
- R8: Filtering is active when `filt_en` or `stat_en` is 1. With both at 0, every valid transfer is stored.
- R9: While `trace_en` is 0 or `freeze` is 1, no transfer is stored and `wr_ptr` and `wrapped` hold their values.
- R10: A read request (`rd_en`, with `rd_addr` = {entry index, word[1:0]}) returns its word on `rd_data` with `rd_valid` high two edges later. One request can be accepted every cycle, including cycles in which a capture writes a different slot.
- R11: One edge after a valid transfer that passes the filters, `ev_hit` pulses, together with `ev_wr` for a write or `ev_rd` for a read. This happens only while `stat_en` is 1, and it does not depend on `trace_en` or `freeze`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Capture enable |
| freeze | input | 1 | Stops capture while high |
| filt_en | input | 1 | Activates the filters |
| stat_en | input | 1 | Enables event outputs and forces the filters on |
| mst_mask | input | 16 | Per-master keep mask |
| slv_mask | input | 16 | Per-slave keep mask |
| keep_rd | input | 1 | Keep read transfers when filtering |
| keep_wr | input | 1 | Keep write transfers when filtering |
| obs_valid | input | 1 | Observed transfer present this cycle |
| obs_addr | input | 32 | Transfer address |
| obs_data | input | 32 | Transfer data |
| obs_write | input | 1 | 1 for write, 0 for read |
| obs_mst | input | 4 | Master id |
| obs_slv | input | 4 | Slave id |
| obs_kind | input | 2 | Transfer kind code |
| rd_en | input | 1 | Read request |
| rd_addr | input | IDX_W+2 | Entry index and word select |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | `rd_data` valid |
| wr_ptr | output | IDX_W | Next slot to be written |
| wrapped | output | 1 | Ring has wrapped at least once |
| ev_hit | output | 1 | Filter-passing transfer event |
| ev_rd | output | 1 | Filter-passing read event |
| ev_wr | output | 1 | Filter-passing write event |

## Verification
The results arrive on two schedules. `wr_ptr`, `wrapped` and the event pulses change on the same edge that samples a transfer, so the bench reads them at the falling edge that follows. Read data appears two edges after the request. The driver presents a transfer at one falling edge and checks the pointer and events at the next falling edge. Read requests push their expected words into a queue, and a monitor pops one entry each time `rd_valid` is high. Any missing or extra words are therefore caught, whether reads are issued back-to-back or alongside captures. Expected timestamps come from a bench cycle counter that is reset with the design.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int WORD_W    = 32;
  localparam int WORDS     = 4;
  localparam int ENTRY_W   = WORD_W * WORDS;
  localparam int ID_W      = 4;
  localparam int NUM_ID    = 1 << ID_W;
  localparam int KIND_W    = 2;
  localparam int TS_LO_W   = 16;
  localparam int PAD_W     = WORD_W - TS_LO_W - 2*ID_W - 1 - KIND_W;

  typedef struct packed {
    logic [WORD_W-1:0] ts;
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] head;
  } entry_t;

  function automatic entry_t pack_entry(
    input logic [WORD_W-1:0] ts,
    input logic [WORD_W-1:0] addr,
    input logic [WORD_W-1:0] data,
    input logic [ID_W-1:0]   mst,
    input logic [ID_W-1:0]   slv,
    input logic              wr,
    input logic [KIND_W-1:0] kind
  );
    entry_t e;
    e.ts   = ts;
    e.data = data;
    e.addr = addr;
    e.head = {ts[TS_LO_W-1:0], mst, slv, wr, kind, {PAD_W{1'b0}}};
    return e;
  endfunction
endpackage

// File: rtl/trace_filter.sv
module trace_filter
  import trace_pkg::*;
(
  input  logic              active,
  input  logic [NUM_ID-1:0] mst_mask,
  input  logic [NUM_ID-1:0] slv_mask,
  input  logic              keep_rd,
  input  logic              keep_wr,
  input  logic [ID_W-1:0]   mst,
  input  logic [ID_W-1:0]   slv,
  input  logic              write,
  output logic              pass
);
  logic dir_ok;
  always_comb begin
    dir_ok = write ? keep_wr : keep_rd;
    pass   = !active || (mst_mask[mst] && slv_mask[slv] && dir_ok);
  end
endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] q,
  output logic [IDX_W-1:0]   wr_ptr,
  output logic               wrapped
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)    mem[wr_ptr] <= wdata;
    if (rd_en) q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (we) begin
      wr_ptr  <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (wr_ptr == LAST) wrapped <= 1'b1;
    end
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (we && wr_ptr == LAST) |=> (wr_ptr == '0 && wrapped));
  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    wrapped |=> wrapped);
endmodule

// File: rtl/trace_readout.sv
module trace_readout
  import trace_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [1:0]         word_sel,
  input  logic [ENTRY_W-1:0] q,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_valid
);
  logic [1:0] sel_q;
  logic       v1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      rd_valid <= 1'b0;
      sel_q    <= '0;
      rd_data  <= '0;
    end else begin
      v1       <= rd_en;
      if (rd_en) sel_q <= word_sel;
      rd_valid <= v1;
      if (v1) rd_data <= q[{sel_q, 5'b0} +: WORD_W];
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rd_valid);
endmodule

// File: rtl/trace_stats.sv
module trace_stats (
  input  logic clk,
  input  logic rst,
  input  logic stat_en,
  input  logic obs_valid,
  input  logic pass,
  input  logic write,
  output logic ev_hit,
  output logic ev_rd,
  output logic ev_wr
);
  logic hit;
  always_comb hit = stat_en && obs_valid && pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_hit <= 1'b0;
      ev_rd  <= 1'b0;
      ev_wr  <= 1'b0;
    end else begin
      ev_hit <= hit;
      ev_rd  <= hit && !write;
      ev_wr  <= hit && write;
    end
  end

  assert_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !stat_en |=> !(ev_hit || ev_rd || ev_wr));
endmodule

// File: rtl/bus_trace_buffer.sv
module bus_trace_buffer
  import trace_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trace_en,
  input  logic                freeze,
  input  logic                filt_en,
  input  logic                stat_en,
  input  logic [15:0]         mst_mask,
  input  logic [15:0]         slv_mask,
  input  logic                keep_rd,
  input  logic                keep_wr,
  input  logic                obs_valid,
  input  logic [31:0]         obs_addr,
  input  logic [31:0]         obs_data,
  input  logic                obs_write,
  input  logic [3:0]          obs_mst,
  input  logic [3:0]          obs_slv,
  input  logic [1:0]          obs_kind,
  input  logic                rd_en,
  input  logic [IDX_W+1:0]    rd_addr,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  output logic [IDX_W-1:0]    wr_ptr,
  output logic                wrapped,
  output logic                ev_hit,
  output logic                ev_rd,
  output logic                ev_wr
);
  logic [WORD_W-1:0]  ts;
  logic               filt_active;
  logic               pass;
  logic               capture;
  entry_t             wentry;
  logic [ENTRY_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

  always_comb begin
    filt_active = filt_en || stat_en;
    capture     = obs_valid && pass && trace_en && !freeze;
    wentry      = pack_entry(ts, obs_addr, obs_data, obs_mst, obs_slv,
                             obs_write, obs_kind);
  end

  trace_filter i_filter (
    .active   (filt_active),
    .mst_mask (mst_mask),
    .slv_mask (slv_mask),
    .keep_rd  (keep_rd),
    .keep_wr  (keep_wr),
    .mst      (obs_mst),
    .slv      (obs_slv),
    .write    (obs_write),
    .pass     (pass)
  );

  trace_store #(.DEPTH(DEPTH)) i_store (
    .clk     (clk),
    .rst     (rst),
    .we      (capture),
    .wdata   (wentry),
    .rd_en   (rd_en),
    .rd_idx  (rd_addr[IDX_W+1:2]),
    .q       (q),
    .wr_ptr  (wr_ptr),
    .wrapped (wrapped)
  );

  trace_readout i_readout (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .word_sel (rd_addr[1:0]),
    .q        (q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  trace_stats i_stats (
    .clk       (clk),
    .rst       (rst),
    .stat_en   (stat_en),
    .obs_valid (obs_valid),
    .pass      (pass),
    .write     (obs_write),
    .ev_hit    (ev_hit),
    .ev_rd     (ev_rd),
    .ev_wr     (ev_wr)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!trace_en || freeze) |=> ($stable(wr_ptr) && $stable(wrapped)));
  assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (capture && filt_active) |-> (mst_mask[obs_mst] && slv_mask[obs_slv]));
  assert_dir_R7: assert property (@(posedge clk) disable iff (rst)
    (capture && filt_active) |-> (obs_write ? keep_wr : keep_rd));
endmodule

// File: tb/test_bus_trace_buffer.sv
module test_bus_trace_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic trace_en = 0, freeze = 0, filt_en = 0, stat_en = 0;
  logic [15:0] mst_mask = '1, slv_mask = '1;
  logic keep_rd = 1, keep_wr = 1;
  logic obs_valid = 0, obs_write = 0;
  logic [31:0] obs_addr = 0, obs_data = 0;
  logic [3:0] obs_mst = 0, obs_slv = 0;
  logic [1:0] obs_kind = 0;
  logic rd_en = 0;
  logic [IDX_W+1:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic rd_valid, wrapped, ev_hit, ev_rd, ev_wr;
  logic [IDX_W-1:0] wr_ptr;

  bus_trace_buffer #(.DEPTH(DEPTH)) i_bus_trace_buffer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int tb_cyc = 0;
  int tb_ptr = 0;
  bit tb_wrapped = 0;
  logic [127:0] exp_mem [DEPTH];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always @(posedge clk) tb_cyc <= rst ? 0 : tb_cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit tb_pass(input bit wr, input logic [3:0] m, input logic [3:0] s);
    if (!(filt_en || stat_en)) return 1;
    return mst_mask[m] && slv_mask[s] && (wr ? keep_wr : keep_rd);
  endfunction

  // drive one transfer; optionally a concurrent read request
  task automatic xfer(input string req, input logic [31:0] a, input logic [31:0] d,
                      input bit wr, input logic [3:0] m, input logic [3:0] s,
                      input logic [1:0] k, input bit with_rd = 0,
                      input int ridx = 0, input int rw = 0);
    bit p, st;
    logic [31:0] t;
    p  = tb_pass(wr, m, s);
    st = p && trace_en && !freeze;
    t  = tb_cyc;
    obs_valid = 1; obs_addr = a; obs_data = d; obs_write = wr;
    obs_mst = m; obs_slv = s; obs_kind = k;
    if (with_rd) begin
      rd_en = 1; rd_addr = {IDX_W'(ridx), 2'(rw)};
      exp_q.push_back(exp_mem[ridx][32*rw +: 32]); tag_q.push_back("R10");
    end
    @(negedge clk);
    obs_valid = 0; rd_en = 0;
    if (st) begin
      exp_mem[tb_ptr] = {t, d, a, t[15:0], m, s, wr, k, 5'b0};
      if (tb_ptr == DEPTH-1) begin tb_ptr = 0; tb_wrapped = 1; end
      else tb_ptr++;
    end
    check(req, 32'(wr_ptr), tb_ptr);
    check(req, 32'(wrapped), 32'(tb_wrapped));
    check("R11", {29'b0, ev_hit, ev_rd, ev_wr},
          {29'b0, stat_en && p, stat_en && p && !wr, stat_en && p && wr});
  endtask

  task automatic rd_word(input int idx, input int w, input string req);
    rd_en = 1; rd_addr = {IDX_W'(idx), 2'(w)};
    exp_q.push_back(exp_mem[idx][32*w +: 32]); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R10", rd_data, 32'hx);
      else begin
        string tg;
        logic [31:0] e;
        e = exp_q.pop_front(); tg = tag_q.pop_front();
        check(tg, rd_data, e);
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", {wr_ptr, wrapped, rd_valid, ev_hit, ev_rd, ev_wr}, '0);
    trace_en = 1;
    // R8 filters off: everything stored; R2 layout; R3 increments
    xfer("R8", 32'h1000_0004, 32'hCAFE_0001, 1, 4'd3, 4'd9, 2'd2);
    xfer("R3", 32'h2000_0008, 32'hBEEF_0002, 0, 4'd15, 4'd0, 2'd3);
    xfer("R3", 32'h3000_000C, 32'h1234_5678, 1, 4'd0, 4'd15, 2'd1);
    for (int e = 0; e < 3; e++)
      for (int w = 0; w < 4; w++) rd_word(e, w, "R2");
    // R5 master mask
    filt_en = 1; mst_mask = 16'h0004;
    xfer("R5", 32'h40, 32'h1, 0, 4'd5, 4'd1, 2'd0);
    xfer("R5", 32'h44, 32'h2, 0, 4'd2, 4'd1, 2'd0);
    // R6 slave mask
    mst_mask = '1; slv_mask = 16'h8000;
    xfer("R6", 32'h48, 32'h3, 1, 4'd1, 4'd7, 2'd0);
    xfer("R6", 32'h4C, 32'h4, 1, 4'd1, 4'd15, 2'd0);
    // R7 direction filter
    slv_mask = '1; keep_wr = 0;
    xfer("R7", 32'h50, 32'h5, 1, 4'd1, 4'd1, 2'd1);
    xfer("R7", 32'h54, 32'h6, 0, 4'd1, 4'd1, 2'd1);
    keep_wr = 1; keep_rd = 0;
    xfer("R7", 32'h58, 32'h7, 0, 4'd1, 4'd1, 2'd1);
    keep_rd = 1;
    // R8 stat_en forces filtering; R11 events
    filt_en = 0; stat_en = 1; mst_mask = 16'h0001;
    xfer("R8", 32'h60, 32'h8, 1, 4'd4, 4'd1, 2'd0);
    xfer("R11", 32'h64, 32'h9, 1, 4'd0, 4'd1, 2'd0);
    xfer("R11", 32'h68, 32'hA, 0, 4'd0, 4'd1, 2'd0);
    // R9 trace disabled / frozen; events still reported
    trace_en = 0;
    xfer("R9", 32'h70, 32'hB, 0, 4'd0, 4'd2, 2'd0);
    trace_en = 1; freeze = 1;
    xfer("R9", 32'h74, 32'hC, 1, 4'd0, 4'd2, 2'd0);
    freeze = 0; stat_en = 0; mst_mask = '1;
    for (int e = 3; e < tb_ptr; e++) rd_word(e, 1, "R5");
    // fill to wrap point
    while (tb_ptr != DEPTH-1)
      xfer("R3", 32'h9000_0000 + tb_ptr, ~tb_ptr, tb_ptr[0], 4'(tb_ptr), 4'(tb_ptr >> 2), 2'(tb_ptr));
    check("R3", 32'(wrapped), 0);
    xfer("R3", 32'hA000_0000, 32'hD00D, 0, 4'd6, 4'd6, 2'd2);
    check("R3", 32'(wrapped), 1);
    // R4 overwrite oldest, neighbours intact; R10 concurrent reads
    xfer("R4", 32'hB000_0000, 32'hE00E, 1, 4'd7, 4'd7, 2'd3, 1, 5, 1);
    xfer("R4", 32'hC000_0000, 32'hF00F, 0, 4'd8, 4'd8, 2'd0, 1, 0, 1);
    rd_word(0, 1, "R4"); rd_word(1, 2, "R4"); rd_word(2, 1, "R4");
    rd_word(1, 0, "R4"); rd_word(DEPTH-1, 3, "R2");
    repeat (4) @(negedge clk);
    check("R10", exp_q.size(), 0);
    finish_run();
  end
endmodule